// File: doc/BRIEF.md
# Segmented Condition Register Unit

This block holds a 32-bit condition register split into eight 4-bit fields and the small amount of logic that maintains it. A comparison result can be written into any field chosen by a 3-bit index. An arithmetic result that is flagged for recording updates field 0 without naming it. A bit-level logic operation reads two addressed register bits, combines them with one of eight boolean functions, and writes the answer into a third addressed bit. A field-move operation copies one whole field onto another.

Bits are numbered from the most significant end, so bit k is `cr_o[31-k]` and field f covers bits 4f to 4f+3, which is `cr_o[31-4f -: 4]`. Inside a field the first bit is less-than, then greater-than, then equal, then the copied summary-overflow flag. Every flag input is packed in the same order, `{lt, gt, eq, so}`. A branch-condition output tests any selected bit of the current register against a requested sense.

The block runs one operation per cycle. Updates land on the next rising clock edge. It has no state machine: the register is its only state. The states named by the design are therefore the register contents, and each operation code is a transition between them.

Top module: `cond_reg_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole register to zero at the next rising edge, and the register is always visible on `cr_o`.
- R2: With `op_i` = 1 (compare), the field chosen by `cmp_field_i` takes `cmp_flags_i` at the next edge. Field f is `cr_o[31-4f -: 4]`, with the less-than flag at the field's most significant position.
- R3: With `op_i` = 0 and `arith_rec_i` high, field 0 (`cr_o[31:28]`) takes `arith_flags_i` at the next edge and all other fields keep their value.
- R4: When a compare targets field 0 in the same cycle as an arithmetic record, field 0 takes the compare flags. When the compare targets another field, both updates take effect.
- R5: With `op_i` = 2 (bit logic), bit `bit_d_i` becomes f(bit `bit_a_i`, bit `bit_b_i`). Both operands are read from the register value before the edge, and all other bits keep their value.
- R6: The function code `fn_i` selects: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 EQV (XNOR), 6 a AND NOT b, 7 a OR NOT b.
- R7: With `op_i` = 3 (field move), field `mv_dst_i` takes the pre-edge value of field `mv_src_i` in one cycle, and the source field is left unchanged.
- R8: A bit-logic or field-move operation issued together with an arithmetic record overrides the arithmetic flags on the bits it writes. The remaining bits of field 0 take the arithmetic flags.
- R9: `branch_o` is 1 exactly when bit `test_bit_i` of the current register equals `test_sense_i`. It is combinational from the register and the test inputs.
- R10: With `op_i` = 0 and `arith_rec_i` low, the register holds its value.
- R11: No update is visible on `cr_o` before the rising edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | Operation: 0 none, 1 compare, 2 bit logic, 3 field move |
| cmp_field_i | input | 3 | Destination field of a compare |
| cmp_flags_i | input | 4 | Compare result {lt, gt, eq, so} |
| arith_rec_i | input | 1 | Record arithmetic flags into field 0 |
| arith_flags_i | input | 4 | Arithmetic result {lt, gt, eq, so} |
| fn_i | input | 3 | Bit-logic function code |
| bit_a_i | input | 5 | First operand bit index |
| bit_b_i | input | 5 | Second operand bit index |
| bit_d_i | input | 5 | Destination bit index |
| mv_src_i | input | 3 | Field-move source field |
| mv_dst_i | input | 3 | Field-move destination field |
| test_bit_i | input | 5 | Bit index tested for the branch condition |
| test_sense_i | input | 1 | Value the tested bit must have for a taken branch |
| cr_o | output | 32 | Current register value |
| branch_o | output | 1 | Branch condition result |

## Verification
On every cycle, the assertions check several behaviours. They cover the cleared state after reset, the landing of compare flags in the addressed field, the arithmetic write to field 0, the compare winning a field-0 conflict, the held value when idle, the AND result of a bit-logic step, and the copy performed by a field move. The bench scenarios are needed for the rest. These cover the full function table, bits outside the written field or bit staying put, the mixed arithmetic and bit-logic overlap, and the branch output across every bit index and both senses. Those results are compared against a model built from the requirements, and sweeps cover every field, flag pattern, function, operand pair and move pair.

// File: rtl/cru_pkg.sv
package cru_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CMP   = 2'd1,
        OP_LOGIC = 2'd2,
        OP_MOVE  = 2'd3
    } crop_e;

    typedef enum logic [2:0] {
        FN_AND  = 3'd0,
        FN_OR   = 3'd1,
        FN_XOR  = 3'd2,
        FN_NAND = 3'd3,
        FN_NOR  = 3'd4,
        FN_EQV  = 3'd5,
        FN_ANDC = 3'd6,
        FN_ORC  = 3'd7
    } bfn_e;

endpackage

// File: rtl/cru_bit_logic.sv
module cru_bit_logic
    import cru_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic [2:0] fn_i,
    output logic       y_o
);
    bfn_e fn;
    assign fn = bfn_e'(fn_i);

    always_comb begin
        unique case (fn)
            FN_AND:  y_o = a_i & b_i;
            FN_OR:   y_o = a_i | b_i;
            FN_XOR:  y_o = a_i ^ b_i;
            FN_NAND: y_o = ~(a_i & b_i);
            FN_NOR:  y_o = ~(a_i | b_i);
            FN_EQV:  y_o = ~(a_i ^ b_i);
            FN_ANDC: y_o = a_i & ~b_i;
            FN_ORC:  y_o = a_i | ~b_i;
            default: y_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cru_bit_pick.sv
module cru_bit_pick #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic [W-1:0]  vec_i,
    input  logic [IW-1:0] idx_i,
    output logic          bit_o
);
    // index 0 names the most significant bit
    assign bit_o = vec_i[W-1-int'(idx_i)];
endmodule

// File: rtl/cru_next.sv
module cru_next
    import cru_pkg::*;
#(
    parameter int NFIELD = 8,
    parameter int FW     = 4,
    localparam int CRW   = NFIELD * FW,
    localparam int IDXW  = $clog2(CRW),
    localparam int FIDXW = $clog2(NFIELD)
) (
    input  logic [CRW-1:0]   cur_i,
    input  logic [1:0]       op_i,
    input  logic [FIDXW-1:0] cmp_field_i,
    input  logic [FW-1:0]    cmp_flags_i,
    input  logic             arith_rec_i,
    input  logic [FW-1:0]    arith_flags_i,
    input  logic [2:0]       fn_i,
    input  logic [IDXW-1:0]  bit_a_i,
    input  logic [IDXW-1:0]  bit_b_i,
    input  logic [IDXW-1:0]  bit_d_i,
    input  logic [FIDXW-1:0] mv_src_i,
    input  logic [FIDXW-1:0] mv_dst_i,
    output logic [CRW-1:0]   nxt_o
);
    crop_e op;
    logic  opnd_a, opnd_b, logic_y;
    logic [FW-1:0] src_field;

    assign op = crop_e'(op_i);

    cru_bit_pick #(.W(CRW), .IW(IDXW)) u_pick_a (
        .vec_i (cur_i),
        .idx_i (bit_a_i),
        .bit_o (opnd_a)
    );

    cru_bit_pick #(.W(CRW), .IW(IDXW)) u_pick_b (
        .vec_i (cur_i),
        .idx_i (bit_b_i),
        .bit_o (opnd_b)
    );

    cru_bit_logic u_logic (
        .a_i  (opnd_a),
        .b_i  (opnd_b),
        .fn_i (fn_i),
        .y_o  (logic_y)
    );

    assign src_field = cur_i[CRW-1-FW*int'(mv_src_i) -: FW];

    always_comb begin
        nxt_o = cur_i;
        // implicit record goes first so any explicit operation overrides it
        if (arith_rec_i) begin
            nxt_o[CRW-1 -: FW] = arith_flags_i;
        end
        unique case (op)
            OP_NONE:  ;
            OP_CMP:   nxt_o[CRW-1-FW*int'(cmp_field_i) -: FW] = cmp_flags_i;
            OP_LOGIC: nxt_o[CRW-1-int'(bit_d_i)] = logic_y;
            OP_MOVE:  nxt_o[CRW-1-FW*int'(mv_dst_i) -: FW] = src_field;
            default:  ;
        endcase
    end
endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit
    import cru_pkg::*;
#(
    parameter int NFIELD = 8,
    parameter int FW     = 4,
    localparam int CRW   = NFIELD * FW,
    localparam int IDXW  = $clog2(CRW),
    localparam int FIDXW = $clog2(NFIELD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op_i,
    input  logic [FIDXW-1:0] cmp_field_i,
    input  logic [FW-1:0]    cmp_flags_i,
    input  logic             arith_rec_i,
    input  logic [FW-1:0]    arith_flags_i,
    input  logic [2:0]       fn_i,
    input  logic [IDXW-1:0]  bit_a_i,
    input  logic [IDXW-1:0]  bit_b_i,
    input  logic [IDXW-1:0]  bit_d_i,
    input  logic [FIDXW-1:0] mv_src_i,
    input  logic [FIDXW-1:0] mv_dst_i,
    input  logic [IDXW-1:0]  test_bit_i,
    input  logic             test_sense_i,
    output logic [CRW-1:0]   cr_o,
    output logic             branch_o
);
    logic [CRW-1:0] cr_q, cr_d;
    logic           tested;
    logic [FW-1:0]  field_view [NFIELD];

    cru_next #(.NFIELD(NFIELD), .FW(FW)) u_next (
        .cur_i         (cr_q),
        .op_i          (op_i),
        .cmp_field_i   (cmp_field_i),
        .cmp_flags_i   (cmp_flags_i),
        .arith_rec_i   (arith_rec_i),
        .arith_flags_i (arith_flags_i),
        .fn_i          (fn_i),
        .bit_a_i       (bit_a_i),
        .bit_b_i       (bit_b_i),
        .bit_d_i       (bit_d_i),
        .mv_src_i      (mv_src_i),
        .mv_dst_i      (mv_dst_i),
        .nxt_o         (cr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q <= '0;
        end else begin
            cr_q <= cr_d;
        end
    end

    cru_bit_pick #(.W(CRW), .IW(IDXW)) u_pick_test (
        .vec_i (cr_q),
        .idx_i (test_bit_i),
        .bit_o (tested)
    );

    assign cr_o     = cr_q;
    assign branch_o = ~(tested ^ test_sense_i);

    // per-field view of the stored register, used by the checks below
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        assign field_view[g] = cr_q[CRW-1-g*FW -: FW];
    end

    function automatic logic [FW-1:0] fld(input logic [CRW-1:0] v, input logic [FIDXW-1:0] f);
        return v[CRW-1-FW*int'(f) -: FW];
    endfunction

    function automatic logic bitat(input logic [CRW-1:0] v, input logic [IDXW-1:0] k);
        return v[CRW-1-int'(k)];
    endfunction

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> cr_o == '0);

    assert_cmp_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd1) |=> fld(cr_o, $past(cmp_field_i)) == $past(cmp_flags_i));

    assert_arith_field0_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd0 && arith_rec_i) |=> field_view[0] == $past(arith_flags_i));

    assert_cmp_beats_arith_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd1 && cmp_field_i == '0 && arith_rec_i)
        |=> field_view[0] == $past(cmp_flags_i));

    assert_and_result_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd2 && fn_i == 3'd0)
        |=> bitat(cr_o, $past(bit_d_i)) == $past(bitat(cr_q, bit_a_i) & bitat(cr_q, bit_b_i)));

    assert_move_copies_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd3) |=> fld(cr_o, $past(mv_dst_i)) == $past(fld(cr_q, mv_src_i)));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd0 && !arith_rec_i) |=> $stable(cr_o));
endmodule

// File: tb/cond_reg_unit_bench.sv
module cond_reg_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_i = 2'd0;
    logic [2:0]  cmp_field_i = '0;
    logic [3:0]  cmp_flags_i = '0;
    logic        arith_rec_i = 1'b0;
    logic [3:0]  arith_flags_i = '0;
    logic [2:0]  fn_i = '0;
    logic [4:0]  bit_a_i = '0, bit_b_i = '0, bit_d_i = '0;
    logic [2:0]  mv_src_i = '0, mv_dst_i = '0;
    logic [4:0]  test_bit_i = '0;
    logic        test_sense_i = 1'b0;
    logic [31:0] cr_o;
    logic        branch_o;

    logic [31:0] model;
    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    cond_reg_unit u_cond_reg_unit (
        .clk, .rst, .op_i, .cmp_field_i, .cmp_flags_i, .arith_rec_i, .arith_flags_i,
        .fn_i, .bit_a_i, .bit_b_i, .bit_d_i, .mv_src_i, .mv_dst_i,
        .test_bit_i, .test_sense_i, .cr_o, .branch_o
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check_cr(input string req);
        checks++;
        if (cr_o !== model) begin
            failures++;
            $display("FAIL %s: cr_o=%h expected=%h", req, cr_o, model);
        end
    endtask

    function automatic logic fnval(input logic [2:0] f, input logic a, input logic b);
        case (f)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a ^ b;
            3'd3: return ~(a & b);
            3'd4: return ~(a | b);
            3'd5: return ~(a ^ b);
            3'd6: return a & ~b;
            default: return a | ~b;
        endcase
    endfunction

    // inputs change 1 ns after an edge, results are read 1 ns after the capturing edge
    task automatic step();
        @(posedge clk);
        #1;
        op_i = 2'd0;
        arith_rec_i = 1'b0;
    endtask

    task automatic do_cmp(input logic [2:0] f, input logic [3:0] fl, input string req);
        op_i = 2'd1; cmp_field_i = f; cmp_flags_i = fl;
        #2;
        checks++;
        if (cr_o !== model) begin
            failures++;
            $display("FAIL R11: early change cr_o=%h expected=%h", cr_o, model);
        end
        step();
        model[31-4*int'(f) -: 4] = fl;
        check_cr(req);
    endtask

    initial begin
        #1;
        step();
        step();
        rst = 1'b0;
        model = '0;
        check_cr("R1");

        // every field with every flag pattern
        for (int f = 0; f < 8; f++) begin
            for (int p = 0; p < 16; p++) begin
                do_cmp(3'(f), 4'(p ^ (f * 5)), "R2");
            end
        end

        // arithmetic record into field 0
        for (int p = 0; p < 16; p++) begin
            arith_rec_i = 1'b1; arith_flags_i = 4'(p);
            step();
            model[31:28] = 4'(p);
            check_cr("R3");
        end

        // idle keeps the value
        repeat (3) begin
            step();
            check_cr("R10");
        end

        // compare and arithmetic together
        op_i = 2'd1; cmp_field_i = 3'd0; cmp_flags_i = 4'b1010;
        arith_rec_i = 1'b1; arith_flags_i = 4'b0101;
        step();
        model[31:28] = 4'b1010;
        check_cr("R4");
        op_i = 2'd1; cmp_field_i = 3'd5; cmp_flags_i = 4'b0011;
        arith_rec_i = 1'b1; arith_flags_i = 4'b1100;
        step();
        model[31:28] = 4'b1100;
        model[31-20 -: 4] = 4'b0011;
        check_cr("R4");

        // function table: bit 0 holds 0, bit 1 holds 1
        do_cmp(3'd0, 4'b0101, "R2");
        for (int f = 0; f < 8; f++) begin
            for (int av = 0; av < 2; av++) begin
                for (int bv = 0; bv < 2; bv++) begin
                    op_i = 2'd2; fn_i = 3'(f);
                    bit_a_i = av[0] ? 5'd1 : 5'd0;
                    bit_b_i = bv[0] ? 5'd3 : 5'd2;
                    bit_d_i = 5'(8 + f * 3 + av * 2 + bv);
                    step();
                    model[31-int'(bit_d_i)] = fnval(3'(f), av[0], bv[0]);
                    check_cr("R6");
                end
            end
        end

        // destination anywhere, operands read before the edge
        for (int d = 0; d < 32; d++) begin
            op_i = 2'd2; fn_i = 3'(d % 8);
            bit_a_i = 5'(d); bit_b_i = 5'((d + 7) % 32); bit_d_i = 5'(d);
            step();
            model[31-d] = fnval(3'(d % 8), model[31-d], model[31-((d + 7) % 32)]);
            check_cr("R5");
        end

        // bit logic overlapping an arithmetic record
        op_i = 2'd2; fn_i = 3'd1; bit_a_i = 5'd10; bit_b_i = 5'd11; bit_d_i = 5'd2;
        arith_rec_i = 1'b1; arith_flags_i = 4'b1011;
        begin
            logic r;
            r = model[31-10] | model[31-11];
            step();
            model[31:28] = 4'b1011;
            model[31-2] = r;
        end
        check_cr("R8");

        // every move pair
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 8; d++) begin
                op_i = 2'd3; mv_src_i = 3'(s); mv_dst_i = 3'(d);
                begin
                    logic [3:0] v;
                    v = model[31-4*s -: 4];
                    step();
                    model[31-4*d -: 4] = v;
                end
                check_cr("R7");
                do_cmp(3'(s), 4'(s * 3 + d), "R2");
            end
        end

        // move into field 0 overlapping an arithmetic record
        op_i = 2'd3; mv_src_i = 3'd6; mv_dst_i = 3'd0;
        arith_rec_i = 1'b1; arith_flags_i = ~model[31-24 -: 4];
        begin
            logic [3:0] v;
            v = model[31-24 -: 4];
            step();
            model[31:28] = v;
        end
        check_cr("R8");

        // branch condition over every bit and both senses
        for (int k = 0; k < 32; k++) begin
            for (int s = 0; s < 2; s++) begin
                test_bit_i = 5'(k); test_sense_i = s[0];
                #1;
                checks++;
                if (branch_o !== (model[31-k] == s[0])) begin
                    failures++;
                    $display("FAIL R9: bit %0d sense %0d branch_o=%b expected=%b",
                             k, s, branch_o, model[31-k] == s[0]);
                end
            end
        end

        // reset from a non-zero state
        rst = 1'b1;
        step();
        rst = 1'b0;
        model = '0;
        check_cr("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule